// File: doc/BRIEF.md
# Five-Level Single-Carrier PWM Modulator

This block drives the five gate signals of a single-phase five-level inverter built from an H-bridge and one auxiliary clamp switch. A phase accumulator advances by a tuning word every enabled cycle. Its upper bit marks the negative half of the fundamental, and the lower bits give a rectified, sine-like reference. The reference is a parabolic fit of |sin|, 4x(1-x) over each half-cycle.

The reference is scaled by a modulation index and by twice the carrier peak, and it is clamped at twice the peak. The scaled value is compared twice against one up/down triangular carrier: once as it is, and once lowered by the carrier peak. These two comparisons pick full, half or zero output magnitude. The fundamental polarity gives the sign.

A decoder turns the signed level into a gate pattern. In that pattern the two low-frequency leg switches are complementary square waves that change state only when the polarity changes. Index values below, at and above unity are accepted, so over-modulation works. The gate outputs, the level code and the polarity flag are registered.

Top module: `pwm5_modulator`

## Requirements
- R1: While reset is high, or in any cycle after a clock edge at which enable was low, gate, level and neg_half are all zero. A low enable also clears the phase accumulator to 0 and restarts the carrier at 0, counting upward.
- R2: At each enabled edge the phase accumulator P (PW bits) advances by freq_word modulo 2^PW. neg_half is bit PW-1 of P, where 1 means the negative half-cycle.
- R3: The carrier C starts at 0 counting up. It steps by 1 up to car_peak and then down to 0, so the sequence is 0,1,..,peak,peak-1,..,0,1,.. with a period of 2*car_peak cycles. C stays 0 when car_peak is 0.
- R4: Let h be the low PW-1 bits of P, with H=PW-1. Then shape = (h*(2^H-h)) >> (2H-2-SW), ref = (shape*mod_idx*2*car_peak) >> (SW+MI_FRAC), and ref is clamped to at most 2*car_peak. mod_idx has MI_FRAC fractional bits, so with MI_FRAC=6 the value 64 means unity.
- R5: If ref > car_peak + C, the magnitude is 2. Otherwise, if ref > C, it is 1. Otherwise it is 0. level is the magnitude as 3-bit two's complement (2=010, 1=001, 0=000, -1=111, -2=110), negated when neg_half is 1.
- R6: The gate bits are gate[0]=S1 (clamp), gate[1]=S2, gate[2]=S3, gate[3]=S4, gate[4]=S5. The patterns are +2 -> 10010, +1 -> 10001, -1 -> 01001 and -2 -> 01100. Level 0 gives 10100 in the positive half and 01010 in the negative half.
- R7: Whenever the block is enabled, exactly two gate bits are high.
- R8: When enabled, gate[4] and gate[3] are complementary, and they keep their values between consecutive enabled samples of the same polarity.
- R9: The outputs reflect the accumulator and carrier values held before the edge that registers them. The first enabled output therefore uses P=0 and C=0.
- R10: With the carrier period dividing the half-period of the fundamental, the level sequence over one fundamental period is odd-symmetric: the level half a period later equals the negated level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low forces gates off and restarts phase and carrier |
| mod_idx | input | MI_W | Modulation index, MI_FRAC fractional bits |
| freq_word | input | PW | Phase increment per cycle (fundamental tuning) |
| car_peak | input | CW | Carrier peak value |
| gate | output | 5 | Gate drives {S5,S4,S3,S2,S1} |
| level | output | 3 | Commanded signed output level |
| neg_half | output | 1 | 1 in the negative half of the fundamental |

## Verification
The bench builds the block with a 12-bit phase, an 8-bit carrier and 12 shape bits. With a tuning word of 4, one fundamental period is then 1024 cycles, and every phase step of several full periods can be checked cycle by cycle against an arithmetic model. A carrier peak of 16 divides the half-period evenly, which brings the half-wave symmetry check within reach. Index values 0, 54, 64, 70 and 80 cover the all-zero case, under-modulation, unity and the clamp of the over-modulated reference. Odd tuning words and peaks, together with enable dropping mid-run, exercise the unaligned carrier and the restart path.

// File: rtl/pwm5_pkg.sv
package pwm5_pkg;
  typedef logic signed [2:0] lvl_t;

  localparam int NGATE = 5;

  // Signed level from a magnitude in 0..2 and the half-cycle sign.
  function automatic lvl_t signed_level(logic [1:0] mag, logic neg);
    lvl_t m;
    m = lvl_t'({1'b0, mag});
    return neg ? -m : m;
  endfunction

  // Gate pattern {S5,S4,S3,S2,S1}; zero level picks its pair by polarity
  // so that the leg switches hold for the whole half-cycle.
  function automatic logic [NGATE-1:0] gate_pattern(lvl_t l, logic neg);
    logic [NGATE-1:0] g;
    case (l)
      3'sd2:   g = 5'b10010;
      3'sd1:   g = 5'b10001;
      -3'sd1:  g = 5'b01001;
      -3'sd2:  g = 5'b01100;
      default: g = neg ? 5'b01010 : 5'b10100;
    endcase
    return g;
  endfunction
endpackage

// File: rtl/pwm5_phase_acc.sv
module pwm5_phase_acc #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [PW-1:0] step,
  output logic [PW-1:0] phase
);
  always_ff @(posedge clk) begin
    if (rst || !run) phase <= '0;
    else             phase <= phase + step;
  end
endmodule

// File: rtl/pwm5_tri_carrier.sv
module pwm5_tri_carrier #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [CW-1:0] peak,
  output logic [CW-1:0] car
);
  logic up;

  always_ff @(posedge clk) begin
    if (rst || !run || peak == '0) begin
      car <= '0;
      up  <= 1'b1;
    end else if (up) begin
      if (car < peak) begin
        car <= car + 1'b1;
      end else begin
        up  <= 1'b0;
        car <= car - 1'b1;
      end
    end else begin
      if (car != '0) begin
        car <= car - 1'b1;
      end else begin
        up  <= 1'b1;
        car <= car + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwm5_ref_cmp.sv
module pwm5_ref_cmp
  import pwm5_pkg::*;
#(
  parameter int PW      = 16,
  parameter int CW      = 10,
  parameter int MI_W    = 8,
  parameter int MI_FRAC = 6,
  parameter int SW      = 12
) (
  input  logic [PW-1:0]   phase,
  input  logic [MI_W-1:0] mod_idx,
  input  logic [CW-1:0]   peak,
  input  logic [CW-1:0]   car,
  output lvl_t            lvl,
  output logic            neg
);
  localparam int H    = PW - 1;
  localparam int PRW  = 2 * H + 1;
  localparam int SHW  = SW + 1;
  localparam int RW   = SHW + MI_W + CW;
  localparam int SH_R = 2 * H - 2 - SW;
  localparam int SH_L = (SH_R < 0) ? -SH_R : 0;
  localparam int DIV  = SW + MI_FRAC - 1;

  logic [H-1:0]   h;
  logic [H:0]     hc;
  logic [PRW-1:0] prod;
  logic [SHW-1:0] shape;
  logic [RW-1:0]  scaled;
  logic [RW-1:0]  ref_full;
  logic [CW:0]    lim;
  logic [CW:0]    ref_c;
  logic [CW:0]    hi_thr;
  logic           full;
  logic           half;

  assign h    = phase[H-1:0];
  assign neg  = phase[PW-1];
  assign hc   = {1'b1, {H{1'b0}}} - {1'b0, h};
  assign prod = PRW'(h) * PRW'(hc);

  // Parabolic |sin| shape, full scale 2^SW at the half-cycle centre.
  generate
    if (SH_R >= 0) begin : g_shr
      assign shape = SHW'(prod >> SH_R);
    end else begin : g_shl
      assign shape = SHW'(prod) << SH_L;
    end
  endgenerate

  // Amplitude = shape * index * 2 * peak; the factor 2 folds into DIV.
  assign scaled   = RW'(shape) * RW'(mod_idx) * RW'(peak);
  assign ref_full = scaled >> DIV;
  assign lim      = {peak, 1'b0};
  assign ref_c    = (ref_full > RW'(lim)) ? lim : ref_full[CW:0];

  assign hi_thr = {1'b0, peak} + {1'b0, car};
  assign full   = ref_c > hi_thr;
  assign half   = ref_c > {1'b0, car};

  always_comb begin
    if (full)      lvl = signed_level(2'd2, neg);
    else if (half) lvl = signed_level(2'd1, neg);
    else           lvl = signed_level(2'd0, neg);
  end
endmodule

// File: rtl/pwm5_modulator.sv
module pwm5_modulator
  import pwm5_pkg::*;
#(
  parameter int PW      = 16,
  parameter int CW      = 10,
  parameter int MI_W    = 8,
  parameter int MI_FRAC = 6,
  parameter int SW      = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [MI_W-1:0] mod_idx,
  input  logic [PW-1:0]   freq_word,
  input  logic [CW-1:0]   car_peak,
  output logic [4:0]      gate,
  output logic [2:0]      level,
  output logic            neg_half
);
  logic [PW-1:0] phase;
  logic [CW-1:0] car;
  lvl_t          lvl_c;
  logic          neg_c;

  pwm5_phase_acc #(.PW(PW)) phase_i (
    .clk(clk), .rst(rst), .run(en), .step(freq_word), .phase(phase)
  );

  pwm5_tri_carrier #(.CW(CW)) carrier_i (
    .clk(clk), .rst(rst), .run(en), .peak(car_peak), .car(car)
  );

  pwm5_ref_cmp #(
    .PW(PW), .CW(CW), .MI_W(MI_W), .MI_FRAC(MI_FRAC), .SW(SW)
  ) cmp_i (
    .phase(phase), .mod_idx(mod_idx), .peak(car_peak), .car(car),
    .lvl(lvl_c), .neg(neg_c)
  );

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      gate     <= '0;
      level    <= '0;
      neg_half <= 1'b0;
    end else begin
      gate     <= gate_pattern(lvl_c, neg_c);
      level    <= lvl_c;
      neg_half <= neg_c;
    end
  end
endmodule

// File: rtl/pwm5_modulator_chk.sv
module pwm5_modulator_chk (
  input logic       clk,
  input logic       rst,
  input logic       en,
  input logic [4:0] gate,
  input logic [2:0] level,
  input logic       neg_half
);
  a_r1_idle_low: assert property (@(posedge clk) disable iff (rst)
    !en |=> (gate == 5'b0 && level == 3'b0 && !neg_half));

  a_r7_two_on: assert property (@(posedge clk) disable iff (rst)
    en |=> $countones(gate) == 2);

  a_r8_legs_compl: assert property (@(posedge clk) disable iff (rst)
    en |=> gate[4] != gate[3]);

  a_r8_legs_hold: assert property (@(posedge clk) disable iff (rst)
    (gate != 5'b0 && $past(gate) != 5'b0 && neg_half == $past(neg_half))
      |-> gate[4:3] == $past(gate[4:3]));

  a_r5_sign_pos: assert property (@(posedge clk) disable iff (rst)
    (gate != 5'b0 && !neg_half) |-> !level[2]);

  a_r5_sign_neg: assert property (@(posedge clk) disable iff (rst)
    neg_half |-> (level == 3'b0 || level[2]));

  a_r6_full_pos: assert property (@(posedge clk) disable iff (rst)
    level == 3'b010 |-> gate == 5'b10010);
endmodule

bind pwm5_modulator pwm5_modulator_chk chk_i (
  .clk(clk), .rst(rst), .en(en), .gate(gate), .level(level),
  .neg_half(neg_half)
);

// File: tb/pwm5_modulator_tb_top.sv
`timescale 1ns/1ps
module pwm5_modulator_tb_top;
  localparam int PW = 12, CW = 8, MW = 8, MF = 6, SW = 12;
  localparam int H = PW - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          en = 1'b0;
  logic [MW-1:0] mi = '0;
  logic [PW-1:0] ftw = '0;
  logic [CW-1:0] pk = '0;
  logic [4:0]    gate;
  logic [2:0]    level;
  logic          neg_half;

  always #4 clk = ~clk;

  pwm5_modulator #(.PW(PW), .CW(CW), .MI_W(MW), .MI_FRAC(MF), .SW(SW)) dut_i (
    .clk(clk), .rst(rst), .en(en), .mod_idx(mi), .freq_word(ftw),
    .car_peak(pk), .gate(gate), .level(level), .neg_half(neg_half)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // model state
  longint mp = 0, mc = 0;
  bit     mup = 1;
  logic [4:0] eg = '0;
  int     el = 0;
  bit     eneg = 0;
  logic [4:0] pg = '0;
  bit     pneg = 0, pvalid = 0;
  int     rec [0:1023];

  task automatic chk(bit ok, string tag, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] map_g(int lv, bit ng);
    case (lv)
      2:  return 5'b10010;
      1:  return 5'b10001;
      -1: return 5'b01001;
      -2: return 5'b01100;
      default: return ng ? 5'b01010 : 5'b10100;
    endcase
  endfunction

  // Expected outputs after the coming edge, then advance model (R1-R5, R9)
  task automatic step();
    longint h, sh, rf, p;
    int mag;
    bit ng;
    if (!en) begin
      eg = '0; el = 0; eneg = 0; mp = 0; mc = 0; mup = 1;
    end else begin
      p  = pk;
      h  = mp % (1 << H);
      ng = (mp >> H) & 1;
      sh = (h * ((1 << H) - h)) >> (2 * H - 2 - SW);
      rf = (sh * mi * 2 * p) >> (SW + MF);
      if (rf > 2 * p) rf = 2 * p;
      if (rf > p + mc)  mag = 2;
      else if (rf > mc) mag = 1;
      else              mag = 0;
      el = ng ? -mag : mag;
      eg = map_g(el, ng);
      eneg = ng;
      mp = (mp + ftw) % (1 << PW);
      if (p == 0) begin mc = 0; mup = 1; end
      else if (mup) begin
        if (mc < p) mc++; else begin mup = 0; mc--; end
      end else begin
        if (mc != 0) mc--; else begin mup = 1; mc++; end
      end
    end
  endtask

  task automatic compare();
    int lv;
    lv = int'($signed(level));
    chk(gate == eg, "R6 gate pattern", gate, eg);
    chk(lv == el, "R5 level (via R3 R4 R9)", lv, el);
    chk(neg_half == eneg, "R2 polarity", neg_half, eneg);
    if (eg == 5'b0) chk(gate == 0 && level == 0 && !neg_half, "R1 idle outputs", gate, 0);
    else begin
      chk($countones(gate) == 2, "R7 two gates on", $countones(gate), 2);
      chk(gate[4] != gate[3], "R8 legs complementary", gate[4:3], 2'b01);
      if (pvalid && neg_half == pneg)
        chk(gate[4:3] == pg[4:3], "R8 legs hold in half-cycle", gate[4:3], pg[4:3]);
    end
    pvalid = (gate != 0);
    pg = gate;
    pneg = neg_half;
  endtask

  task automatic run(int n, bit e, int m, int f, int p, bit r);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
      if (r && i >= 1 && i <= 1024) rec[i-1] = int'($signed(level));
      en = e; mi = MW'(m); ftw = PW'(f); pk = CW'(p);
      step();
    end
  endtask

  task automatic sym();
    for (int i = 0; i < 512; i++)
      chk(rec[i+512] == -rec[i], "R10 half-wave symmetry", rec[i+512], -rec[i]);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(gate == 0, "R1 reset gate", gate, 0);
    chk(level == 0, "R1 reset level", level, 0);
    chk(neg_half == 0, "R1 reset polarity", neg_half, 0);
    rst = 1'b0;
    step();
    run(4, 0, 0, 0, 0, 0);
    run(1025, 1, 54, 4, 16, 1); sym();
    run(3, 0, 0, 0, 0, 0);
    run(1025, 1, 64, 4, 16, 1); sym();
    run(3, 0, 0, 0, 0, 0);
    run(1025, 1, 80, 4, 16, 1); sym();
    run(3, 0, 0, 0, 0, 0);
    run(600, 1, 80, 7, 13, 0);
    run(5, 0, 80, 7, 13, 0);
    run(600, 1, 0, 9, 13, 0);
    run(300, 1, 70, 33, 5, 0);
    run(5, 0, 0, 0, 0, 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule